// File: doc/BRIEF.md
# Stereo Sample Attenuator with Soft Mute

The block scales a two-channel stream of signed 24-bit samples, one pair per sample strobe. Each channel has an 8-bit level code: the top code passes the sample unchanged, each lower code removes a further 0.5 dB, and code zero silences the channel. Code changes are held back until the channel's own signal passes through zero, which keeps level changes free of clicks. Zero-cross holding can be turned off, and then a new code applies from the next sample.

Beyond scaling, the block offers a soft mute. A mute lets the output die away exponentially from its last value instead of stepping to zero, and a release returns straight to the live signal. A right-follows-left option lets one code drive both channels. Phase reversal negates both outputs. Each channel also has an active-low flag that drops after a long unbroken run of zero input samples, and the two flags can be merged so that both drop only when both channels are silent.

Top module: `stereo_atten`

## Requirements
- R1: With code c (1..255) and s = 255 - c, the output is floor((x*M*2^-15) / 2^(s/12) + 1/2), where s/12 is integer division and M comes from s mod 12 through the set 0:32768, 1:30935, 2:29205, 3:27571, 4:26029, 5:24573, 6:23198, 7:21900, 8:20675, 9:19519, 10:18427, 11:17396. So code 0xFF is unity, 0xF3 halves and 0xE7 quarters the sample.
- R2: Code 0x00 drives the channel output to 0 whatever the input.
- R3: With zero-cross holding enabled, a channel takes its new code only on a sample that is exactly zero, follows an exactly zero sample, or has a sign bit differing from the previous sample's; that sample already uses the new code, and all others keep the last taken code.
- R4: With zero-cross holding disabled, the code present on the port is used for the next sample.
- R5: With the copy bit set, the right channel is scaled with the left code; after clearing it, the right channel uses its own code again.
- R6: Phase reversal negates each output, saturating so that -8388608 becomes 8388607.
- R7: While mute is set, each strobe replaces the output y with y - d, where d = y >>> 6 (arithmetic), raised to 1 when y is positive and d would be 0; the input sample has no effect, and the output reaches 0 and stays there.
- R8: On the first strobe with mute clear, the output is the scaled current input.
- R9: A channel's condition is true when more than ZERO_RUN consecutive strobed samples of that channel were exactly zero; any non-zero sample clears it. Independently, each flag pin is the inverse of its own channel's condition.
- R10: With flag combining set, both flag pins are low only when both channel conditions are true, and high otherwise.
- R11: After reset both outputs are 0, both flags are high and both channels' taken codes are 0xFF.
- R12: Outputs change one clock after a cycle with the strobe high and hold in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample pair |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| code_l | input | 8 | Left level code |
| code_r | input | 8 | Right level code |
| mute | input | 1 | Soft mute for both channels |
| zc_en | input | 1 | 1 holds code changes until a zero crossing |
| copy_lr | input | 1 | 1 scales the right channel with the left code |
| rev | input | 1 | 1 negates both outputs |
| comb_flags | input | 1 | 1 drives both flags with the combined condition |
| out_l | output | 24 | Left output sample, signed |
| out_r | output | 24 | Right output sample, signed |
| zflag_l_n | output | 1 | Left zero-run flag, active low |
| zflag_r_n | output | 1 | Right zero-run flag, active low |

## Verification
The bench builds the block with ZERO_RUN set to 8 and keeps the 24-bit samples and 8-bit codes at their defaults. With that run length the flag edge between the eighth and ninth zero sample, its clearing and the combined flag mode can be reached in a few dozen strobes. The full-width samples bring the negation saturation at the most negative value and the deepest code (21 octaves of shift) into reach.

// File: rtl/atten_pkg.sv
// Shared constants and helpers for the stereo attenuator.
// Assumes a 0.5 dB step law with 12 steps per 6 dB octave.
package atten_pkg;
    localparam int MANT_W        = 16;  // unsigned mantissa width
    localparam int FRAC_BITS     = 15;  // mantissa binary point
    localparam int STEPS_PER_OCT = 12;

    // Gain of k half-dB steps inside one octave, scaled by 2^FRAC_BITS.
    function automatic logic [MANT_W-1:0] half_db_mant(input int k);
        case (k)
            0:       return 16'd32768;
            1:       return 16'd30935;
            2:       return 16'd29205;
            3:       return 16'd27571;
            4:       return 16'd26029;
            5:       return 16'd24573;
            6:       return 16'd23198;
            7:       return 16'd21900;
            8:       return 16'd20675;
            9:       return 16'd19519;
            10:      return 16'd18427;
            default: return 16'd17396;
        endcase
    endfunction
endpackage

// File: rtl/atten_gain_sel.sv
// Chooses the level code a channel applies to the current sample.
// A code change is taken on a zero crossing (or at once when holding is off).
// Assumes samples arrive only in cycles with valid high.
module atten_gain_sel #(
    parameter int DW = 24,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic signed [DW-1:0] smp,
    input  logic [CW-1:0]        target,
    input  logic                 zc_en,
    output logic [CW-1:0]        eff_code
);
    logic signed [DW-1:0] prev_q;
    logic [CW-1:0]        taken_q;
    logic                 crossing;
    logic                 take;

    // Detect a zero crossing against the previous strobed sample.
    always_comb begin
        crossing = (smp == '0) || (prev_q == '0) || (smp[DW-1] != prev_q[DW-1]);
        take     = !zc_en || crossing;
        eff_code = take ? target : taken_q;
    end

    // Remember the last sample and the last code taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            taken_q <= '1;
        end else if (valid) begin
            prev_q <= smp;
            if (take) taken_q <= target;
        end
    end
endmodule

// File: rtl/atten_scale.sv
// Combinational gain stage: fractional-octave mantissa multiply, octave shift,
// round half up, saturate, optional negation. Code zero gives silence.
module atten_scale #(
    parameter int DW = 24,
    parameter int CW = 8
) (
    input  logic signed [DW-1:0] x,
    input  logic [CW-1:0]        code,
    input  logic                 rev,
    output logic signed [DW-1:0] y
);
    import atten_pkg::*;

    localparam int STEPS_MAX = (1 << CW) - 1;
    localparam int AW        = DW + MANT_W + 2;
    localparam logic signed [AW-1:0] POS_LIM = $signed({{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}});
    localparam logic signed [AW-1:0] NEG_LIM = $signed({{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}});

    int                   steps;
    int                   oct;
    int                   frac;
    logic signed [MANT_W:0] mant_s;
    logic signed [AW-1:0] prod;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] sh;
    logic signed [AW-1:0] lim;
    logic signed [AW-1:0] negd;

    // Split the code into octaves and half-dB steps, then scale the sample.
    always_comb begin
        steps  = STEPS_MAX - int'(code);
        oct    = steps / STEPS_PER_OCT;
        frac   = steps % STEPS_PER_OCT;
        mant_s = $signed({1'b0, half_db_mant(frac)});
        prod   = AW'(x) * AW'(mant_s);
        acc    = prod + (AW'(1) <<< (FRAC_BITS - 1 + oct));
        sh     = acc >>> (FRAC_BITS + oct);
    end

    // Saturate to the sample width and apply phase reversal.
    always_comb begin
        if (sh > POS_LIM)      lim = POS_LIM;
        else if (sh < NEG_LIM) lim = NEG_LIM;
        else                   lim = sh;
        negd = -lim;
        if (negd > POS_LIM) negd = POS_LIM;
        if (code == '0)     y = '0;
        else if (rev)       y = negd[DW-1:0];
        else                y = lim[DW-1:0];
    end
endmodule

// File: rtl/zero_run_det.sv
// Counts consecutive exactly-zero strobed samples of one channel.
// hit is true once more than RUN zeros in a row were seen.
module zero_run_det #(
    parameter int DW  = 24,
    parameter int RUN = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic signed [DW-1:0] smp,
    output logic                 hit
);
    localparam int CNT_W = $clog2(RUN + 2);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(RUN + 1);

    logic [CNT_W-1:0] cnt_q;

    // Saturating run counter, cleared by any non-zero sample.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (valid) begin
            if (smp != '0)      cnt_q <= '0;
            else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Condition reached once the counter sits at its limit.
    always_comb hit = (cnt_q == LIM);
endmodule

// File: rtl/stereo_atten.sv
// Stereo attenuator top: per-channel code selection, scaling, soft-mute
// output register and zero-run flags. Channel 0 is left, channel 1 right.
// Assumes in_valid is a single-cycle strobe per sample pair.
module stereo_atten #(
    parameter int DW         = 24,
    parameter int CW         = 8,
    parameter int ZERO_RUN   = 1024,
    parameter int MUTE_SHIFT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_l,
    input  logic signed [DW-1:0] in_r,
    input  logic [CW-1:0]        code_l,
    input  logic [CW-1:0]        code_r,
    input  logic                 mute,
    input  logic                 zc_en,
    input  logic                 copy_lr,
    input  logic                 rev,
    input  logic                 comb_flags,
    output logic signed [DW-1:0] out_l,
    output logic signed [DW-1:0] out_r,
    output logic                 zflag_l_n,
    output logic                 zflag_r_n
);
    localparam int NCH = 2;

    logic signed [DW-1:0] smp    [NCH];
    logic [CW-1:0]        tgt    [NCH];
    logic [CW-1:0]        eff    [NCH];
    logic signed [DW-1:0] scaled [NCH];
    logic signed [DW-1:0] y_q    [NCH];
    logic                 hit    [NCH];

    // Route ports to per-channel arrays; right may follow the left code.
    always_comb begin
        smp[0] = in_l;
        smp[1] = in_r;
        tgt[0] = code_l;
        tgt[1] = copy_lr ? code_l : code_r;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic signed [DW-1:0] dec;
        logic signed [DW-1:0] decayed;

        atten_gain_sel #(.DW(DW), .CW(CW)) u_sel (
            .clk(clk), .rst_n(rst_n), .valid(in_valid), .smp(smp[ch]),
            .target(tgt[ch]), .zc_en(zc_en), .eff_code(eff[ch])
        );

        atten_scale #(.DW(DW), .CW(CW)) u_scale (
            .x(smp[ch]), .code(eff[ch]), .rev(rev), .y(scaled[ch])
        );

        zero_run_det #(.DW(DW), .RUN(ZERO_RUN)) u_zero (
            .clk(clk), .rst_n(rst_n), .valid(in_valid), .smp(smp[ch]), .hit(hit[ch])
        );

        // One exponential decay step that always moves toward zero.
        always_comb begin
            dec = y_q[ch] >>> MUTE_SHIFT;
            if (dec == '0 && !y_q[ch][DW-1] && y_q[ch] != '0) dec = DW'(1);
            decayed = y_q[ch] - dec;
        end

        // Output register: decays while muted, else takes the scaled sample.
        always_ff @(posedge clk) begin
            if (!rst_n)        y_q[ch] <= '0;
            else if (in_valid) y_q[ch] <= mute ? decayed : scaled[ch];
        end
    end

    // Drive outputs and flags, merging the conditions when asked.
    always_comb begin
        out_l = y_q[0];
        out_r = y_q[1];
        if (comb_flags) begin
            zflag_l_n = !(hit[0] && hit[1]);
            zflag_r_n = !(hit[0] && hit[1]);
        end else begin
            zflag_l_n = !hit[0];
            zflag_r_n = !hit[1];
        end
    end
endmodule

// File: rtl/stereo_atten_chk.sv
// Property checker for stereo_atten, attached by bind below.
module stereo_atten_chk #(
    parameter int DW = 24,
    parameter int CW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_l,
    input logic [CW-1:0]        code_l,
    input logic                 mute,
    input logic                 zc_en,
    input logic                 rev,
    input logic                 comb_flags,
    input logic signed [DW-1:0] out_l,
    input logic signed [DW-1:0] out_r,
    input logic                 zflag_l_n,
    input logic                 zflag_r_n
);
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_l) && $stable(out_r))); // R12

    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute && !zc_en && code_l == '0) |=> (out_l == '0)); // R2

    AST_MUTE_SHRINK_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute && !out_l[DW-1]) |=> (!out_l[DW-1] && out_l <= $past(out_l))); // R7

    AST_MUTE_SHRINK_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute && out_l[DW-1]) |=> (out_l >= $past(out_l) && (out_l[DW-1] || out_l == '0))); // R7

    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute && !rev && !zc_en && code_l == '1) |=> (out_l == $past(in_l))); // R8

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_l != '0) |=> zflag_l_n); // R9

    AST_FLAG_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
        comb_flags |-> (zflag_l_n == zflag_r_n)); // R10
endmodule

bind stereo_atten stereo_atten_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .code_l(code_l),
    .mute(mute), .zc_en(zc_en), .rev(rev), .comb_flags(comb_flags),
    .out_l(out_l), .out_r(out_r), .zflag_l_n(zflag_l_n), .zflag_r_n(zflag_r_n)
);

// File: tb/stereo_atten_bench.sv
module stereo_atten_bench;
    localparam int DW = 24;
    localparam int CW = 8;
    localparam int RUN = 8;
    localparam int NV = 9;

    // Table: code, sample, expected output (R1, R2 gain law, holding off).
    localparam logic [7:0] V_CODE [NV] = '{8'hFF, 8'hF3, 8'hF3, 8'hF3, 8'hE7, 8'hFE, 8'h00, 8'hFF, 8'h01};
    localparam int         V_X    [NV] = '{1000, 1000, 1001, -1001, 4000, 32768, 5000, -8388608, 8388607};
    localparam int         V_EXP  [NV] = '{1000, 500, 501, -500, 1000, 30935, 0, -8388608, 4};

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic signed [DW-1:0] in_l = '0, in_r = '0;
    logic [CW-1:0] code_l = 8'hFF, code_r = 8'hFF;
    logic mute = 0, zc_en = 0, copy_lr = 0, rev = 0, comb_flags = 0;
    logic signed [DW-1:0] out_l, out_r;
    logic zflag_l_n, zflag_r_n;
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    stereo_atten #(.DW(DW), .CW(CW), .ZERO_RUN(RUN), .MUTE_SHIFT(6)) u_stereo_atten (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
        .code_l(code_l), .code_r(code_r), .mute(mute), .zc_en(zc_en),
        .copy_lr(copy_lr), .rev(rev), .comb_flags(comb_flags),
        .out_l(out_l), .out_r(out_r), .zflag_l_n(zflag_l_n), .zflag_r_n(zflag_r_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d exp=<20000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Drive one strobe at a falling edge; outputs are sampled one edge later.
    task automatic send(input int l, input int r);
        @(negedge clk);
        in_l = DW'(l); in_r = DW'(r); in_valid = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 out_l", int'(out_l), 0);
        chk("R11 out_r", int'(out_r), 0);
        chk("R11 flag_l", int'(zflag_l_n), 1);
        chk("R11 flag_r", int'(zflag_r_n), 1);

        for (int i = 0; i < NV; i++) begin
            code_l = V_CODE[i]; code_r = V_CODE[i];
            send(V_X[i], V_X[i]);
            chk(V_CODE[i] == 8'h00 ? "R2 left" : "R1 left", int'(out_l), V_EXP[i]);
            chk(V_CODE[i] == 8'h00 ? "R2 right" : "R1 right", int'(out_r), V_EXP[i]);
        end

        // R12: no strobe keeps outputs.
        in_l = 24'sd777; repeat (3) @(negedge clk);
        chk("R12 hold", int'(out_l), 4);

        // R4: holding off applies the port code to the next sample.
        code_l = 8'hFF; code_r = 8'hFF;
        send(1000, 1000);
        chk("R4 next sample", int'(out_l), 1000);

        // R3: holding on.
        zc_en = 1; code_l = 8'hF3; code_r = 8'hF3;
        send(3000, 3000);
        chk("R3 no crossing keeps old", int'(out_l), 3000);
        send(-3000, -3000);
        chk("R3 sign change takes new", int'(out_l), -1500);
        send(-3000, -3000);
        chk("R3 stays new", int'(out_l), -1500);
        code_l = 8'hE7; code_r = 8'hE7;
        send(-4000, -4000);
        chk("R3 held before zero", int'(out_l), -2000);
        send(0, 0);
        chk("R3 zero sample", int'(out_l), 0);
        send(4000, 4000);
        chk("R3 after zero takes new", int'(out_l), 1000);
        zc_en = 0;

        // R5: copy left code to right.
        code_l = 8'hF3; code_r = 8'hFF; copy_lr = 1;
        send(1000, 1000);
        chk("R5 right follows left", int'(out_r), 500);
        copy_lr = 0;
        send(1000, 1000);
        chk("R5 right own code", int'(out_r), 1000);
        chk("R5 left", int'(out_l), 500);

        // R6: phase reversal with saturation.
        code_l = 8'hFF; rev = 1;
        send(1000, -8388608);
        chk("R6 negate", int'(out_l), -1000);
        chk("R6 saturate", int'(out_r), 8388607);
        rev = 0;

        // R7 and R8: soft mute.
        send(6400, -6400);
        mute = 1;
        send(5000, 5000);
        chk("R7 first step", int'(out_l), 6300);
        chk("R7 negative step", int'(out_r), -6300);
        send(-9000, 0);
        chk("R7 second step", int'(out_l), 6202);
        mute = 0;
        send(777, 10);
        chk("R8 release", int'(out_l), 777);
        mute = 1;
        for (int k = 0; k < 10; k++) send(123, 123);
        chk("R7 reaches zero", int'(out_r), 0);
        send(123, 123);
        chk("R7 stays zero", int'(out_r), 0);
        mute = 0;

        // R9 and R10: zero-run flags.
        send(5, 5);
        for (int k = 0; k < RUN; k++) send(0, 0);
        chk("R9 not yet", int'(zflag_l_n), 1);
        send(0, 0);
        chk("R9 left low", int'(zflag_l_n), 0);
        chk("R9 right low", int'(zflag_r_n), 0);
        send(9, 0);
        chk("R9 left cleared", int'(zflag_l_n), 1);
        chk("R9 right still low", int'(zflag_r_n), 0);
        comb_flags = 1;
        @(negedge clk);
        chk("R10 one side only", int'(zflag_r_n), 1);
        for (int k = 0; k <= RUN; k++) send(0, 0);
        chk("R10 both low l", int'(zflag_l_n), 0);
        chk("R10 both low r", int'(zflag_r_n), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule